// File: doc/BRIEF.md
# Multi-Channel Pulse-Width Modulator with Pair Joining

This block generates pulse-width modulated waveforms on a set of output pins, eight by default. Every channel has an 8-bit counter, a period register, a duty register and three mode bits held in shared byte-wide control registers: an enable, an invert bit that picks the idle level, and a center bit that selects up/down counting instead of up-only counting. Software programs the block over a small byte-wide register bus. A one-cycle count enable from an external prescaler advances all running counters.

Two neighbouring channels can be joined into one 16-bit channel for finer resolution. The even channel's registers form the upper byte and the odd channel's registers form the lower byte. The joined channel runs from the odd channel's mode bits and drives the odd channel's pin. A change to a join bit is held until both channels of its pair are stopped. Period and duty writes are staged and only take effect at a period boundary or while the channel is stopped, so a running waveform never sees a half-updated setting.

Top module: `pwm_bank`

## Requirements
- R1: Register map, with n the channel number: enable at 0x00, invert at 0x01, center at 0x04, join at 0x05 (bit k joins channels 2k and 2k+1), counter at 0x08+n, period at 0x10+n, duty at 0x18+n. In the first three registers bit n belongs to channel n. After reset every register reads zero and every pin is low.
- R2: With center=0, the counter counts 0 up to period-1 and wraps. The pin is active while the counter is below duty, so in any window of period ticks it is active for exactly min(duty, period) ticks. The active level is high when the invert bit is 0 and low when it is 1.
- R3: With center=1, the counter counts up from 0 to period and then down to 1, for a cycle of 2*period ticks. In any window of that length the pin is active for exactly 2*min(duty, period) ticks.
- R4: A period or duty write to an enabled channel does not change the waveform before the counter's current period ends.
- R5: A write to a channel's counter address resets that counter to 0.
- R6: While a channel is disabled, its pin holds the idle level (the value of its invert bit) and its counter reads 0.
- R7: Counters advance only in cycles with cnt_tick high.
- R8: In a joined pair, period and duty are the 16-bit values {even, odd}. The odd channel's enable, invert and center bits control the pair, the waveform appears on the odd pin, and the even pin holds the even channel's idle level.
- R9: In a joined pair, the even counter address returns the upper byte of the 16-bit count and the odd counter address returns the lower byte. A write to either counter address resets the whole 16-bit count.
- R10: A join bit takes effect only while both channels of its pair are disabled. Reading the join register returns the bits currently in effect.
- R11: Bits and registers for channels or pairs beyond NUM_CH ignore writes and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | CW | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | CW | Read data for bus_addr (combinational) |
| cnt_tick | input | 1 | Count enable from the prescaler |
| pwm_o | output | NUM_CH | PWM pins, one per channel |

## Verification
The bench builds the block with NUM_CH=6, so pair 6/7 and channels 6 and 7 do not exist. This makes the write-ignore and read-zero behaviour of absent bits and registers observable on the bus, while three real pairs remain for joining. With CW=8, a joined pair has a period of a few hundred ticks. This keeps a full 16-bit period and the counter byte split within a short run.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_ENABLE = 5'h00;
    localparam logic [ADDR_W-1:0] A_INVERT = 5'h01;
    localparam logic [ADDR_W-1:0] A_CENTER = 5'h04;
    localparam logic [ADDR_W-1:0] A_JOIN   = 5'h05;

    typedef enum logic [2:0] {
        RK_NONE, RK_ENABLE, RK_INVERT, RK_CENTER,
        RK_JOIN, RK_COUNT, RK_PERIOD, RK_DUTY
    } reg_kind_t;

    typedef struct packed {
        logic en;
        logic inv;
        logic center;
    } ch_mode_t;

    // Upper two address bits select a per-channel bank; bank 0 holds controls.
    function automatic reg_kind_t decode_kind(input logic [ADDR_W-1:0] a);
        case (a[4:3])
            2'b01:   return RK_COUNT;
            2'b10:   return RK_PERIOD;
            2'b11:   return RK_DUTY;
            default: begin
                if (a == A_ENABLE)      return RK_ENABLE;
                else if (a == A_INVERT) return RK_INVERT;
                else if (a == A_CENTER) return RK_CENTER;
                else if (a == A_JOIN)   return RK_JOIN;
                else                    return RK_NONE;
            end
        endcase
    endfunction

endpackage

// File: rtl/pwm_bank_engine.sv
module pwm_bank_engine #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         en,
    input  logic         inv,
    input  logic         center,
    input  logic         clr,
    input  logic [W-1:0] period_sh,
    input  logic [W-1:0] duty_sh,
    output logic         pin,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q, per_a, duty_a;
    logic         down_q, active;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            down_q <= 1'b0;
            per_a  <= '0;
            duty_a <= '0;
        end else if (!en || clr) begin
            cnt_q  <= '0;
            down_q <= 1'b0;
            per_a  <= period_sh;
            duty_a <= duty_sh;
        end else if (tick && per_a != '0) begin
            if (!down_q) begin
                if (cnt_q == per_a - ONE) begin
                    if (center) begin
                        cnt_q  <= per_a;
                        down_q <= 1'b1;
                    end else begin
                        cnt_q  <= '0;
                        per_a  <= period_sh;
                        duty_a <= duty_sh;
                    end
                end else begin
                    cnt_q <= cnt_q + ONE;
                end
            end else if (cnt_q <= ONE) begin
                cnt_q  <= '0;
                down_q <= 1'b0;
                per_a  <= period_sh;
                duty_a <= duty_sh;
            end else begin
                cnt_q <= cnt_q - ONE;
            end
        end
    end

    always_comb begin
        active = down_q ? (cnt_q <= duty_a) : (cnt_q < duty_a);
        pin    = (en && active) ? !inv : inv;
    end

    assign count = cnt_q;

    // R4
    shadow_load_chk: assert property (@(posedge clk) disable iff (rst)
        (per_a != $past(per_a) || duty_a != $past(duty_a)) |-> (cnt_q == '0 && !down_q));

    // R6
    idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt_q == '0));

    // R7
    tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !tick && !clr) |=> (cnt_q == $past(cnt_q) && down_q == $past(down_q)));

    // R2
    count_range_chk: assert property (@(posedge clk) disable iff (rst)
        (!down_q && per_a != '0) |-> (cnt_q < per_a));

endmodule

// File: rtl/pwm_bank_pair.sv
module pwm_bank_pair
    import pwm_bank_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          join_i,
    input  ch_mode_t      mode_e,
    input  ch_mode_t      mode_o,
    input  logic [CW-1:0] per_e,
    input  logic [CW-1:0] per_o,
    input  logic [CW-1:0] duty_e,
    input  logic [CW-1:0] duty_o,
    input  logic          clr_e,
    input  logic          clr_o,
    output logic          pin_e,
    output logic          pin_o,
    output logic [CW-1:0] view_e,
    output logic [CW-1:0] view_o
);
    localparam int WW = 2 * CW;

    ch_mode_t      mode_w;
    logic [WW-1:0] per_w, duty_w, cnt_w;
    logic [CW-1:0] cnt_n;
    logic          clr_w, out_w, out_n;

    // Wide engine serves the even channel alone, or the whole pair when joined.
    always_comb begin
        if (join_i) begin
            mode_w = mode_o;
            per_w  = {per_e, per_o};
            duty_w = {duty_e, duty_o};
            clr_w  = clr_e | clr_o;
        end else begin
            mode_w = mode_e;
            per_w  = {{CW{1'b0}}, per_e};
            duty_w = {{CW{1'b0}}, duty_e};
            clr_w  = clr_e;
        end
    end

    pwm_bank_engine #(.W(WW)) u_wide (
        .clk(clk), .rst(rst), .tick(tick),
        .en(mode_w.en), .inv(mode_w.inv), .center(mode_w.center), .clr(clr_w),
        .period_sh(per_w), .duty_sh(duty_w), .pin(out_w), .count(cnt_w)
    );

    pwm_bank_engine #(.W(CW)) u_narrow (
        .clk(clk), .rst(rst), .tick(tick),
        .en(mode_o.en && !join_i), .inv(mode_o.inv), .center(mode_o.center), .clr(clr_o),
        .period_sh(per_o), .duty_sh(duty_o), .pin(out_n), .count(cnt_n)
    );

    always_comb begin
        pin_e  = join_i ? mode_e.inv        : out_w;
        pin_o  = join_i ? out_w             : out_n;
        view_e = join_i ? cnt_w[WW-1:CW]    : cnt_w[CW-1:0];
        view_o = join_i ? cnt_w[CW-1:0]     : cnt_n;
    end

endmodule

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CW     = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [CW-1:0]                wdata,
    input  logic                         we,
    input  logic [NUM_CH-1:0][CW-1:0]    cnt_view,
    output logic [CW-1:0]                rdata,
    output ch_mode_t [NUM_CH-1:0]        mode,
    output logic [NUM_CH-1:0][CW-1:0]    per,
    output logic [NUM_CH-1:0][CW-1:0]    duty,
    output logic [NUM_CH-1:0]            clr,
    output logic [NUM_CH/2-1:0]          join_o
);
    localparam int NUM_PAIR = NUM_CH / 2;

    reg_kind_t                kind;
    logic [2:0]               idx;
    logic [NUM_CH-1:0]        en_q, inv_q, ctr_q;
    logic [NUM_PAIR-1:0]      join_req_q, join_q;
    logic [NUM_CH-1:0][CW-1:0] per_q, duty_q;

    assign kind = decode_kind(addr);
    assign idx  = addr[2:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q       <= '0;
            inv_q      <= '0;
            ctr_q      <= '0;
            join_req_q <= '0;
            join_q     <= '0;
            per_q      <= '0;
            duty_q     <= '0;
        end else begin
            if (we) begin
                case (kind)
                    RK_ENABLE: en_q       <= wdata[NUM_CH-1:0];
                    RK_INVERT: inv_q      <= wdata[NUM_CH-1:0];
                    RK_CENTER: ctr_q      <= wdata[NUM_CH-1:0];
                    RK_JOIN:   join_req_q <= wdata[NUM_PAIR-1:0];
                    default: ;
                endcase
            end
            for (int i = 0; i < NUM_CH; i++) begin
                if (we && idx == 3'(i) && kind == RK_PERIOD) per_q[i]  <= wdata;
                if (we && idx == 3'(i) && kind == RK_DUTY)   duty_q[i] <= wdata;
            end
            for (int k = 0; k < NUM_PAIR; k++) begin
                if (!en_q[2*k] && !en_q[2*k+1]) join_q[k] <= join_req_q[k];
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (kind)
            RK_ENABLE: rdata[NUM_CH-1:0]   = en_q;
            RK_INVERT: rdata[NUM_CH-1:0]   = inv_q;
            RK_CENTER: rdata[NUM_CH-1:0]   = ctr_q;
            RK_JOIN:   rdata[NUM_PAIR-1:0] = join_q;
            default: ;
        endcase
        for (int i = 0; i < NUM_CH; i++) begin
            clr[i]  = we && kind == RK_COUNT && idx == 3'(i);
            mode[i] = '{en: en_q[i], inv: inv_q[i], center: ctr_q[i]};
            if (idx == 3'(i)) begin
                if (kind == RK_COUNT)  rdata = cnt_view[i];
                if (kind == RK_PERIOD) rdata = per_q[i];
                if (kind == RK_DUTY)   rdata = duty_q[i];
            end
        end
    end

    assign per    = per_q;
    assign duty   = duty_q;
    assign join_o = join_q;

    for (genvar k = 0; k < NUM_PAIR; k++) begin : g_join_chk
        // R10
        join_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (join_q[k] != $past(join_q[k])) |->
                ($past(en_q[2*k]) == 1'b0 && $past(en_q[2*k+1]) == 1'b0));
    end

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CW     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CW-1:0]     bus_wdata,
    input  logic              bus_we,
    output logic [CW-1:0]     bus_rdata,
    input  logic              cnt_tick,
    output logic [NUM_CH-1:0] pwm_o
);
    localparam int NUM_PAIR = NUM_CH / 2;

    ch_mode_t [NUM_CH-1:0]     mode;
    logic [NUM_CH-1:0][CW-1:0] per, duty, cnt_view;
    logic [NUM_CH-1:0]         clr;
    logic [NUM_PAIR-1:0]       join_en;

    pwm_bank_regs #(.NUM_CH(NUM_CH), .CW(CW)) u_regs (
        .clk(clk), .rst(rst), .addr(bus_addr), .wdata(bus_wdata), .we(bus_we),
        .cnt_view(cnt_view), .rdata(bus_rdata), .mode(mode), .per(per), .duty(duty),
        .clr(clr), .join_o(join_en)
    );

    for (genvar k = 0; k < NUM_PAIR; k++) begin : g_pair
        pwm_bank_pair #(.CW(CW)) u_pair (
            .clk(clk), .rst(rst), .tick(cnt_tick), .join_i(join_en[k]),
            .mode_e(mode[2*k]), .mode_o(mode[2*k+1]),
            .per_e(per[2*k]), .per_o(per[2*k+1]),
            .duty_e(duty[2*k]), .duty_o(duty[2*k+1]),
            .clr_e(clr[2*k]), .clr_o(clr[2*k+1]),
            .pin_e(pwm_o[2*k]), .pin_o(pwm_o[2*k+1]),
            .view_e(cnt_view[2*k]), .view_o(cnt_view[2*k+1])
        );
    end

endmodule

// File: tb/pwm_bank_tb_top.sv
module pwm_bank_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 6;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [4:0]     bus_addr = '0;
    logic [7:0]     bus_wdata = '0;
    logic           bus_we = 1'b0;
    logic [7:0]     bus_rdata;
    logic           cnt_tick = 1'b0;
    logic [NCH-1:0] pwm_o;

    int checks = 0;
    int errors = 0;

    pwm_bank #(.NUM_CH(NCH), .CW(8)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .cnt_tick(cnt_tick), .pwm_o(pwm_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int exp_active(int per, int duty, bit center);
        int m = (duty < per) ? duty : per;
        return center ? 2 * m : m;
    endfunction

    function automatic int window_len(int per, bit center);
        return center ? 2 * per : per;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_now(input logic [4:0] a, output int d);
        bus_addr = a;
        #1;
        d = int'(bus_rdata);
    endtask

    task automatic measure(int ch, int win, logic idle, output int n);
        n = 0;
        repeat (win) begin
            @(negedge clk);
            if (pwm_o[ch] != idle) n++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v, n, n0, bad;
        int per[NCH], duty[NCH];
        bit inv[NCH], ctr[NCH];
        logic [7:0] inv_m, ctr_m;
        v = int'($urandom(32'd7));

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state of registers and pins
        bad = 0;
        for (int a = 0; a < 32; a++) begin
            rd_now(5'(a), v);
            if (v != 0) bad++;
        end
        chk("R1 registers zero after reset", bad, 0);
        chk("R1 pins low after reset", int'(pwm_o), 0);
        cnt_tick = 1'b1;

        // R2/R3 directed corners
        per  = '{8, 1, 3, 5, 4, 6};
        duty = '{3, 1, 3, 0, 9, 2};
        inv  = '{0, 0, 0, 0, 1, 0};
        ctr  = '{0, 0, 1, 0, 0, 1};
        for (int c = 0; c < NCH; c++) begin
            wr(5'(8'h10 + c), 8'(per[c]));
            wr(5'(8'h18 + c), 8'(duty[c]));
        end
        wr(5'h01, 8'b0001_0000);
        wr(5'h04, 8'b0010_0100);
        wr(5'h00, 8'h3F);
        for (int c = 0; c < NCH; c++) begin
            measure(c, window_len(per[c], ctr[c]), inv[c], n);
            chk(ctr[c] ? "R3 center active count" : "R2 left active count",
                n, exp_active(per[c], duty[c], ctr[c]));
        end

        // R2/R3 constrained random
        for (int r = 0; r < 4; r++) begin
            wr(5'h00, 8'h00);
            inv_m = '0; ctr_m = '0;
            for (int c = 0; c < NCH; c++) begin
                per[c]  = int'($urandom_range(20, 1));
                duty[c] = int'($urandom_range(24, 0));
                inv[c]  = 1'($urandom_range(1, 0));
                ctr[c]  = 1'($urandom_range(1, 0));
                inv_m[c] = inv[c]; ctr_m[c] = ctr[c];
                wr(5'(8'h10 + c), 8'(per[c]));
                wr(5'(8'h18 + c), 8'(duty[c]));
            end
            wr(5'h01, inv_m);
            wr(5'h04, ctr_m);
            wr(5'h00, 8'h3F);
            for (int c = 0; c < NCH; c++) begin
                measure(c, window_len(per[c], ctr[c]), inv[c], n);
                chk(ctr[c] ? "R3 random center" : "R2 random left",
                    n, exp_active(per[c], duty[c], ctr[c]));
            end
        end

        // R4: staged duty on channel 2
        wr(5'h00, 8'h00);
        wr(5'h01, 8'h00);
        wr(5'h04, 8'h00);
        wr(5'h12, 8'd10);
        wr(5'h1A, 8'd3);
        wr(5'h00, 8'h04);
        for (int t = 0; t < 40; t++) begin
            @(negedge clk);
            rd_now(5'h0A, v);
            if (v == 4) break;
        end
        wr(5'h1A, 8'd7);
        chk("R4 old duty kept before wrap", int'(pwm_o[2]), 0);
        for (int t = 0; t < 40; t++) begin
            @(negedge clk);
            rd_now(5'h0A, v);
            if (v == 0) break;
        end
        measure(2, 10, 1'b0, n);
        chk("R4 new duty after wrap", n, 7);

        // R5: counter write clears
        for (int t = 0; t < 40; t++) begin
            @(negedge clk);
            rd_now(5'h0A, v);
            if (v > 2) break;
        end
        wr(5'h0A, 8'hA5);
        rd_now(5'h0A, v);
        chk("R5 counter cleared", v, 0);

        // R7: tick gating
        @(negedge clk);
        cnt_tick = 1'b0;
        rd_now(5'h0A, n0);
        repeat (5) @(negedge clk);
        rd_now(5'h0A, v);
        chk("R7 counter frozen without tick", v, n0);
        cnt_tick = 1'b1;
        repeat (2) @(negedge clk);
        rd_now(5'h0A, v);
        chk("R7 counter moves with tick", v, (n0 + 2) % 10);

        // R6: disabled channel idles at invert level
        wr(5'h01, 8'h04);
        wr(5'h00, 8'h00);
        @(negedge clk);
        rd_now(5'h0A, v);
        chk("R6 disabled counter", v, 0);
        measure(2, 12, 1'b1, n);
        chk("R6 disabled pin at idle", n, 0);

        // R11: absent channel bits and registers
        wr(5'h01, 8'hFF); rd_now(5'h01, v); chk("R11 invert mask", v, 8'h3F);
        wr(5'h04, 8'hFF); rd_now(5'h04, v); chk("R11 center mask", v, 8'h3F);
        wr(5'h05, 8'hFF); @(negedge clk); rd_now(5'h05, v); chk("R11 join mask", v, 8'h07);
        wr(5'h00, 8'hFF); rd_now(5'h00, v); chk("R11 enable mask", v, 8'h3F);
        wr(5'h00, 8'h00);
        wr(5'h16, 8'h55); rd_now(5'h16, v); chk("R11 absent period", v, 0);
        wr(5'h1F, 8'h55); rd_now(5'h1F, v); chk("R11 absent duty", v, 0);
        rd_now(5'h0E, v); chk("R11 absent counter", v, 0);

        // R8: joined pair 0/1
        wr(5'h05, 8'h01);
        wr(5'h01, 8'h01);
        wr(5'h04, 8'h00);
        wr(5'h10, 8'h01); wr(5'h11, 8'h2C);
        wr(5'h18, 8'h00); wr(5'h19, 8'h64);
        wr(5'h00, 8'h02);
        n = 0; n0 = 0;
        repeat (300) begin
            @(negedge clk);
            if (pwm_o[1] != 1'b0) n++;
            if (pwm_o[0] != 1'b1) n0++;
        end
        chk("R8 joined active count", n, 100);
        chk("R8 even pin idle", n0, 0);

        // R9 and R7: 16-bit counter split
        cnt_tick = 1'b0;
        wr(5'h09, 8'h00);
        cnt_tick = 1'b1;
        repeat (260) @(posedge clk);
        @(negedge clk);
        cnt_tick = 1'b0;
        rd_now(5'h08, v); chk("R9 joined counter high byte", v, 8'h01);
        rd_now(5'h09, v); chk("R9 joined counter low byte", v, 8'h04);
        repeat (5) @(negedge clk);
        rd_now(5'h09, v); chk("R7 joined counter frozen", v, 8'h04);
        cnt_tick = 1'b1;

        // R10: join change held while pair enabled
        wr(5'h05, 8'h00);
        @(negedge clk);
        rd_now(5'h05, v); chk("R10 join held while enabled", v, 8'h01);
        wr(5'h00, 8'h00);
        @(negedge clk);
        rd_now(5'h05, v); chk("R10 join applied after disable", v, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule